// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a small 8-bit controller core and external code and data memories. The core raises a request carrying a kind (code fetch, data read or data write), a 16-bit address and, for writes, a data byte. It then holds that request until the block reports completion. The block runs every access inside one fixed machine cycle of 12 clock periods. The cycle is split into six states of two clocks each, and a free-running sequencer produces it.

On the external side, the address high byte goes out on a dedicated port for the whole access. The low address byte and the data byte share one bidirectional port, modelled as separate out, output-enable and in buses. The low address byte goes out first, together with an address-latch pulse, so that an external latch can capture it. The port then carries data during an active-low strobe. There are three strobes: one for code reads, one for data reads and one for data writes. Code and data are separate 64 KB spaces.

An internal-ROM enable input selects where code fetches go. While it is high, fetches below the internal ROM size are served from an on-chip ROM port with no bus activity. While it is low, every fetch uses the bus.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, busy and done are 0, the latch pulse and the port output-enable are 0, and all three strobes are 1.
- R2: A request is accepted only at a machine-cycle boundary. Busy then stays high for exactly 12 clocks, and done is a single-clock pulse in the clock right after busy falls. The read byte is valid while done is high.
- R3: Only one access runs per machine cycle. A request presented in the clock that done is high is accepted 12 clocks later, and busy rises 12 clocks after that clock.
- R4: During an external access, the high port carries address bits 15..8 in all 12 clocks.
- R5: During an external access, the shared port drives address bits 7..0 in clocks 0..3 of the access, and the latch pulse is high only in clocks 0..1.
- R6: A data read (kind 01) holds the data-read strobe low in clocks 4..9 and releases the shared port from clock 4 onward. The result is the port input value present in clock 9.
- R7: A data write (kind 10) holds the write strobe low in clocks 4..9 and drives the write byte on the shared port in clocks 4..10. The port is released in clock 11.
- R8: An external code fetch (kind 00) holds the code strobe low in clocks 4..9 and captures the port input present in clock 9. The data strobes stay high.
- R9: With the internal-ROM enable high and address bits 15..12 zero, a code fetch uses no latch pulse, strobe or output-enable. It presents the low 12 address bits on the ROM address port and returns the ROM data present in clock 9.
- R10: With the internal-ROM enable low, every code fetch is external, at any address.
- R11: At most one strobe is low at any time, and none is low outside an access.
- R12: Data reads and writes are always external, whatever the internal-ROM enable or the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until done |
| req_kind | input | 2 | 00 code fetch, 01 data read, 10 data write |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_busy | output | 1 | Access in progress |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 8 | Byte returned by a read or fetch |
| rom_on | input | 1 | High: low code addresses served internally |
| rom_addr | output | 12 | Internal ROM address |
| rom_data | input | 8 | Internal ROM read data |
| bus_hi | output | 8 | Address high byte port |
| bus_ad_out | output | 8 | Shared port output value |
| bus_ad_oe | output | 1 | Shared port output enable |
| bus_ad_in | input | 8 | Shared port input value |
| bus_ale | output | 1 | Address latch pulse |
| bus_code_n | output | 1 | Code read strobe, active low |
| bus_rd_n | output | 1 | Data read strobe, active low |
| bus_wr_n | output | 1 | Data write strobe, active low |

## Verification
The assertions assume that the core holds the request fields steady from the clock it raises valid until the done pulse, and that it drops valid in that done clock. They also assume that the kind is one of the three defined codes. The bench keeps to this: it changes the request fields only while idle or in the done clock, and it draws kinds only from 00, 01 and 10. It also holds the pad input and ROM data constant over each access, so that the captured byte is well defined. Random idle gaps of 0 to 5 clocks between accesses test acceptance at machine-cycle boundaries, and directed cases test the internal-ROM limit.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam logic [1:0] K_CODE  = 2'b00;
  localparam logic [1:0] K_READ  = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int PHASES = 12,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] ph_q,
  output logic [PW-1:0] ph_nx,
  output logic          last
);
  always_comb begin
    last  = (ph_q == PW'(PHASES - 1));
    ph_nx = last ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_nx;
  end

  a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
    ph_q <= PW'(PHASES - 1));
endmodule

// File: rtl/xbus_req.sv
module xbus_req
  import xbus_pkg::*;
#(
  parameter int ROM_AW = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        last,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        rom_on,
  output logic        act_q,
  output logic        act_nx,
  output logic [1:0]  kind_q,
  output logic [1:0]  kind_nx,
  output logic [15:0] addr_q,
  output logic [15:0] addr_nx,
  output logic [7:0]  wdata_nx,
  output logic        ext_q,
  output logic        ext_nx,
  output logic        done_q
);
  logic       start, finish, code_int;
  logic [7:0] wdata_q;

  always_comb begin
    start    = last && !act_q && req_valid;
    finish   = last && act_q;
    code_int = rom_on && (req_addr[15:ROM_AW] == '0);
    act_nx   = start || (act_q && !finish);
    kind_nx  = start ? req_kind  : kind_q;
    addr_nx  = start ? req_addr  : addr_q;
    wdata_nx = start ? req_wdata : wdata_q;
    ext_nx   = start ? !(req_kind == K_CODE && code_int) : ext_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      kind_q  <= K_CODE;
      addr_q  <= '0;
      wdata_q <= '0;
      ext_q   <= 1'b0;
    end else begin
      act_q   <= act_nx;
      done_q  <= finish;
      kind_q  <= kind_nx;
      addr_q  <= addr_nx;
      wdata_q <= wdata_nx;
      ext_q   <= ext_nx;
    end
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r2_done_follows_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!act_q && $past(act_q)));
  a_r3_hold_mid_cycle: assert property (@(posedge clk) disable iff (rst)
    (act_q && !last) |=> act_q);
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int PHASES = 12,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] ph_q,
  input  logic [PW-1:0] ph_nx,
  input  logic          act_q,
  input  logic          act_nx,
  input  logic [1:0]    kind_q,
  input  logic [1:0]    kind_nx,
  input  logic [15:0]   addr_nx,
  input  logic [7:0]    wdata_nx,
  input  logic          ext_q,
  input  logic          ext_nx,
  input  logic [7:0]    bus_ad_in,
  input  logic [7:0]    rom_data,
  output logic [7:0]    bus_hi,
  output logic [7:0]    bus_ad_out,
  output logic          bus_ad_oe,
  output logic          bus_ale,
  output logic          bus_code_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [7:0]    rdata
);
  localparam int STLEN    = PHASES / 6;
  localparam int ALE_END  = STLEN - 1;
  localparam int ADDR_END = 2 * STLEN - 1;
  localparam int STB_BEG  = 2 * STLEN;
  localparam int STB_END  = 5 * STLEN - 1;
  localparam int WDAT_END = 5 * STLEN;

  logic on, is_wr, is_code, in_addr, in_stb;

  always_comb begin
    on      = act_nx && ext_nx;
    is_wr   = (kind_nx == K_WRITE);
    is_code = (kind_nx == K_CODE);
    in_addr = (ph_nx <= PW'(ADDR_END));
    in_stb  = (ph_nx >= PW'(STB_BEG)) && (ph_nx <= PW'(STB_END));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_hi     <= '0;
      bus_ad_out <= '0;
      bus_ad_oe  <= 1'b0;
      bus_ale    <= 1'b0;
      bus_code_n <= 1'b1;
      bus_rd_n   <= 1'b1;
      bus_wr_n   <= 1'b1;
      rdata      <= '0;
    end else begin
      if (on) bus_hi <= addr_nx[15:8];
      bus_ale    <= on && (ph_nx <= PW'(ALE_END));
      bus_ad_oe  <= on && (in_addr || (is_wr && ph_nx <= PW'(WDAT_END)));
      bus_ad_out <= in_addr ? addr_nx[7:0] : wdata_nx;
      bus_code_n <= !(on && is_code && in_stb);
      bus_wr_n   <= !(on && is_wr && in_stb);
      bus_rd_n   <= !(on && !is_wr && !is_code && in_stb);
      if (act_q && ph_q == PW'(STB_END) && kind_q != K_WRITE)
        rdata <= ext_q ? bus_ad_in : rom_data;
    end
  end

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({!bus_code_n, !bus_rd_n, !bus_wr_n}) <= 1);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!act_q && ph_q != '0) |-> (bus_code_n && bus_rd_n && bus_wr_n && !bus_ale));
  a_r5_ale_no_strobe: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> (bus_code_n && bus_rd_n && bus_wr_n && bus_ad_oe));
  a_r4_hi_stable: assert property (@(posedge clk) disable iff (rst)
    (act_q && ext_q && ph_q != '0) |-> $stable(bus_hi));
  a_r7_write_drives: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> bus_ad_oe);
  a_r6_read_released: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_code_n) |-> !bus_ad_oe);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int PHASES = 12,
  parameter int ROM_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [15:0]       req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_busy,
  output logic              req_done,
  output logic [7:0]        req_rdata,
  input  logic              rom_on,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  output logic [7:0]        bus_hi,
  output logic [7:0]        bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [7:0]        bus_ad_in,
  output logic              bus_ale,
  output logic              bus_code_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  localparam int PW = $clog2(PHASES);

  logic [PW-1:0] ph_q, ph_nx;
  logic          last, act_q, act_nx, ext_q, ext_nx, done_q;
  logic [1:0]    kind_q, kind_nx;
  logic [15:0]   addr_q, addr_nx;
  logic [7:0]    wdata_nx;

  xbus_seq #(.PHASES(PHASES), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .ph_q(ph_q), .ph_nx(ph_nx), .last(last)
  );

  xbus_req #(.ROM_AW(ROM_AW)) u_req (
    .clk(clk), .rst(rst), .last(last), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rom_on(rom_on), .act_q(act_q), .act_nx(act_nx), .kind_q(kind_q),
    .kind_nx(kind_nx), .addr_q(addr_q), .addr_nx(addr_nx),
    .wdata_nx(wdata_nx), .ext_q(ext_q), .ext_nx(ext_nx), .done_q(done_q)
  );

  xbus_pins #(.PHASES(PHASES), .PW(PW)) u_pins (
    .clk(clk), .rst(rst), .ph_q(ph_q), .ph_nx(ph_nx), .act_q(act_q),
    .act_nx(act_nx), .kind_q(kind_q), .kind_nx(kind_nx), .addr_nx(addr_nx),
    .wdata_nx(wdata_nx), .ext_q(ext_q), .ext_nx(ext_nx),
    .bus_ad_in(bus_ad_in), .rom_data(rom_data), .bus_hi(bus_hi),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ale(bus_ale),
    .bus_code_n(bus_code_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .rdata(req_rdata)
  );

  assign req_busy = act_q;
  assign req_done = done_q;
  assign rom_addr = addr_q[ROM_AW-1:0];

  a_r9_internal_silent: assert property (@(posedge clk) disable iff (rst)
    (act_q && !ext_q) |-> (!bus_ale && !bus_ad_oe && bus_code_n && bus_rd_n && bus_wr_n));
  a_r12_data_external: assert property (@(posedge clk) disable iff (rst)
    (act_q && kind_q != K_CODE) |-> ext_q);
endmodule

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
  localparam int ROM_AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_busy, req_done;
  logic [7:0] req_rdata;
  logic rom_on = 1'b1;
  logic [ROM_AW-1:0] rom_addr;
  logic [7:0] rom_data = '0;
  logic [7:0] bus_hi, bus_ad_out;
  logic bus_ad_oe;
  logic [7:0] bus_ad_in = '0;
  logic bus_ale, bus_code_n, bus_rd_n, bus_wr_n;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  xbus_ctrl #(.PHASES(12), .ROM_AW(ROM_AW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_busy(req_busy),
    .req_done(req_done), .req_rdata(req_rdata), .rom_on(rom_on),
    .rom_addr(rom_addr), .rom_data(rom_data), .bus_hi(bus_hi),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_ale(bus_ale), .bus_code_n(bus_code_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n)
  );

  function automatic bit exp_ext(input logic [1:0] k, input logic [15:0] a, input logic ro);
    return (k != 2'b00) || !ro || (a[15:ROM_AW] != '0);
  endfunction

  // Expected {ale, oe, rd_n, wr_n, code_n, hi, port} in access clock i
  function automatic logic [20:0] exp_pins(input logic [1:0] k, input logic [15:0] a,
                                           input logic [7:0] wd, input bit ext, input int i);
    logic ale, oe, rdn, wrn, cdn;
    logic [7:0] port;
    bit stb;
    stb  = (i >= 4) && (i <= 9);
    ale  = ext && (i <= 1);
    oe   = ext && ((i <= 3) || (k == 2'b10 && i <= 10));
    rdn  = !(ext && k == 2'b01 && stb);
    wrn  = !(ext && k == 2'b10 && stb);
    cdn  = !(ext && k == 2'b00 && stb);
    port = !oe ? 8'h00 : (i <= 3 ? a[7:0] : wd);
    return {ale, oe, rdn, wrn, cdn, (ext ? a[15:8] : 8'h00), port};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Starts at a negedge; ends at the negedge where done is visible.
  task automatic run_access(input logic [1:0] k, input logic [15:0] a, input logic [7:0] wd,
                            input logic ro, input logic [7:0] din, input logic [7:0] rd,
                            input int exp_wait);
    int waited;
    bit ext;
    logic [20:0] ev, av;
    rom_on = ro; bus_ad_in = din; rom_data = rd;
    req_kind = k; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    waited = 0;
    while (!req_busy && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    if (exp_wait >= 0)
      check(waited == exp_wait, "R2 R3 accept at machine-cycle boundary", waited, exp_wait);
    ext = exp_ext(k, a, ro);
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      ev = exp_pins(k, a, wd, ext, i);
      av = {bus_ale, bus_ad_oe, bus_rd_n, bus_wr_n, bus_code_n,
            (ext ? bus_hi : 8'h00), (bus_ad_oe ? bus_ad_out : 8'h00)};
      check(av == ev && req_busy, "R4 R5 R6 R7 R8 R11 pin timing", {10'd0, req_busy, av}, {11'd1, ev});
      if (!ext)
        check(rom_addr == a[ROM_AW-1:0], "R9 rom address", rom_addr, a[ROM_AW-1:0]);
    end
    @(negedge clk);
    check(req_done && !req_busy, "R2 done pulse after 12 clocks", {req_done, req_busy}, 2'b10);
    if (k != 2'b10)
      check(req_rdata == (ext ? din : rd), "R6 R8 R9 captured byte", req_rdata, (ext ? din : rd));
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check({req_busy, req_done, bus_ale, bus_ad_oe, bus_rd_n, bus_wr_n, bus_code_n} == 7'b0000111,
          "R1 reset state", {req_busy, req_done, bus_ale, bus_ad_oe, bus_rd_n, bus_wr_n, bus_code_n},
          7'b0000111);
    // R9: internal fetch at top of internal ROM
    run_access(2'b00, 16'h0FFF, 8'h00, 1'b1, 8'h5A, 8'hC3, -1);
    // R9 boundary: first address past the internal ROM is external; R3 back-to-back
    run_access(2'b00, 16'h1000, 8'h00, 1'b1, 8'h77, 8'h11, 12);
    // R10: internal ROM disabled, low address goes external
    run_access(2'b00, 16'h0000, 8'h00, 1'b0, 8'hE1, 8'h22, 12);
    // R12: data read at a low address with internal ROM enabled stays external
    run_access(2'b01, 16'h0010, 8'h00, 1'b1, 8'h3C, 8'h99, 12);
    // R7: write at the top of data space
    run_access(2'b10, 16'hFFFF, 8'hA5, 1'b1, 8'h00, 8'h00, 12);
    // Random mix with idle gaps of 0..5 clocks
    for (int n = 0; n < 60; n++) begin
      logic [1:0] k;
      logic [15:0] a;
      int gap;
      k = 2'($urandom_range(0, 2));
      a = 16'($urandom);
      if ($urandom_range(0, 1) == 1) a[15:ROM_AW] = '0;
      gap = $urandom_range(0, 5);
      repeat (gap) @(negedge clk);
      run_access(k, a, 8'($urandom), 1'($urandom_range(0, 1)), 8'($urandom),
                 8'($urandom), 12 - gap);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule